// File: doc/BRIEF.md
# UTOPIA Transmit Cell Buffer

This block sits on the transmit side of a 25.6/51.2 Mbps ATM physical-layer device. An ATM-layer device writes 53-byte cells into it over an 8-bit UTOPIA Level 1 style bus: one byte per clock, with an active-low enable, a start-of-cell marker and an odd-parity bit. The block holds up to three cells. It offers a cell to the downstream transmit framer only once every byte of that cell has arrived.

Downstream, the framer pulls the stored data one nibble at a time through a valid/read handshake. The high nibble of each byte comes first, and a marker flags the first nibble of every cell. The write side checks parity and flags errors without discarding data. It drops writes that arrive while the buffer is full and records that event in a sticky flag. It also discards a partial cell when a new start-of-cell interrupts it. A transmit LED output is driven low for a fixed stretch of clock cycles whenever a new cell starts.

Top module: `utx_cell_buffer`

## Requirements
- R1: A byte is taken only on a rising clock edge at which `tx_en_n` is 0. Any edge with `tx_en_n` at 1 leaves the stored data, the flags and the LED unchanged.
- R2: `tx_cav` is 1 when fewer than 3 complete cells are held (written but not fully read out), and 0 when 3 are held.
- R3: `nib_vld` stays 0 until the 53rd byte of a cell has been written. It becomes 1 in the cycle after the edge that writes that byte, provided no other cell is already being offered.
- R4: Parity is odd over the 9 bits `{tx_data, tx_par}`. For every stored byte whose 9 bits contain an even number of ones, `par_err` is 1 for exactly the following cycle. The byte is stored and delivered unchanged.
- R5: While `nib_vld` is 1 and `nib_rd` is 0, `nib` and `nib_soc` hold their values. A nibble is consumed on each edge with both at 1. `nib_soc` is 1 exactly on the first nibble of each cell.
- R6: Each byte is delivered as two nibbles, bits [7:4] first and then bits [3:0]. Cells leave in the order in which they were completed.
- R7: A start-of-cell byte that is accepted drives `led_n` to 0 for exactly 223 clock cycles, starting with the cycle after the edge that accepts it. A new accepted start reloads the full count.
- R8: A clock edge with `rst_n` at 0 empties the buffer and clears all counters and flags. After reset, `tx_cav`=1, `nib_vld`=0, `par_err`=0, `ovf_flag`=0 and `led_n`=1.
- R9: A byte with `tx_soc`=1 that arrives in the middle of a cell discards the partial cell. Writing restarts at byte 0 of the same slot.
- R10: A write attempted while `tx_cav` is 0 is dropped and sets `ovf_flag`. The flag stays 1 until reset.
- R11: Bytes written with `tx_soc`=0 when no cell is in progress are ignored. Nothing is stored and no flag changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_data | input | 8 | Cell byte from the ATM-layer device |
| tx_par | input | 1 | Odd parity bit covering `tx_data` |
| tx_soc | input | 1 | Marks the first byte of a cell |
| tx_en_n | input | 1 | Write enable, active low |
| tx_cav | output | 1 | Room for at least one complete cell |
| nib_rd | input | 1 | Downstream consumes the current nibble |
| nib_vld | output | 1 | A complete cell is being offered |
| nib | output | 4 | Current nibble, high half of each byte first |
| nib_soc | output | 1 | Current nibble is the first of a cell |
| par_err | output | 1 | One-cycle pulse after a stored byte with bad parity |
| ovf_flag | output | 1 | Sticky: a write was dropped while full |
| led_n | output | 1 | Transmit LED, low for a stretch after each cell start |

## Verification
The bench first sends bytes with the enable high and bytes without a start marker. The buffer must then stay empty, which separates a correct byte filter from one that stores every byte on the bus. A start marker that cuts into a partial cell, followed by a whole cell, shows whether the partial bytes really vanish or leak into the output. The bench then fills all three slots and writes one more cell. This shows the point where the cell-available flag drops, confirms that dropped bytes never replace stored ones, and shows the flag rising again after one drain. A sweep of all 256 byte values, with parity spoiled on every third byte, tells pulses tied to bad bytes from shifted or stretched pulses and confirms that the flagged bytes come out intact and high nibble first.

// File: rtl/utxb_pkg.sv
// Shared definitions for the UTOPIA transmit cell buffer.
// Assumes byte-wide cell data split into two nibbles.
package utxb_pkg;

    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;

    // What the write side does with the byte on the bus this cycle.
    typedef enum logic [1:0] {
        WR_NONE,       // enable not asserted
        WR_STORE,      // byte goes into the current slot
        WR_FULL_DROP,  // no free slot: dropped, overflow noted
        WR_STRAY       // no cell in progress and no start: ignored
    } wr_act_e;

    // True when the 9 bits fail the odd-parity rule.
    function automatic logic parity_bad(input logic [DATA_W-1:0] d, input logic p);
        return ~(^{d, p});
    endfunction

endpackage

// File: rtl/utxb_wr_ctrl.sv
// Write-side control: decides per byte whether to store, drop or ignore it,
// tracks the slot and byte position of the cell being written, commits a
// cell after its last byte, and raises the parity and overflow flags.
// Assumes `room` is 1 whenever the write slot is free of committed data.
module utxb_wr_ctrl
    import utxb_pkg::*;
#(
    parameter int CELLS      = 3,
    parameter int CELL_BYTES = 53,
    parameter int SLOT_W     = 2,
    parameter int BYTE_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data,
    input  logic              par,
    input  logic              soc,
    input  logic              en_n,
    input  logic              room,
    output logic              we,
    output logic [SLOT_W-1:0] wslot,
    output logic [BYTE_W-1:0] wbyte,
    output logic              commit,
    output logic              soc_ok,
    output logic              par_err,
    output logic              ovf
);

    localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(CELL_BYTES - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(CELLS - 1);

    wr_act_e           act;
    logic              in_cell;
    logic [BYTE_W-1:0] pos;
    logic [SLOT_W-1:0] slot;

    // Classify the byte on the bus.
    always_comb begin
        act = WR_NONE;
        if (!en_n) begin
            if (!room)                act = WR_FULL_DROP;
            else if (soc || in_cell)  act = WR_STORE;
            else                      act = WR_STRAY;
        end
    end

    assign we     = (act == WR_STORE);
    assign wbyte  = soc ? '0 : pos;
    assign wslot  = slot;
    assign commit = we && (wbyte == LAST_BYTE);
    assign soc_ok = we && soc;

    // Advance position and slot, and register the flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_cell <= 1'b0;
            pos     <= '0;
            slot    <= '0;
            par_err <= 1'b0;
            ovf     <= 1'b0;
        end else begin
            par_err <= we && parity_bad(data, par);
            if (act == WR_FULL_DROP) ovf <= 1'b1;
            if (we) begin
                if (commit) begin
                    in_cell <= 1'b0;
                    pos     <= '0;
                    slot    <= (slot == LAST_SLOT) ? '0 : slot + 1'b1;
                end else begin
                    in_cell <= 1'b1;
                    pos     <= wbyte + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/utxb_store.sv
// Cell storage: one byte array per slot with a single write port and a
// combinational read port. Holds no reset; validity is tracked elsewhere.
module utxb_store
    import utxb_pkg::*;
#(
    parameter int CELLS      = 3,
    parameter int CELL_BYTES = 53,
    parameter int SLOT_W     = 2,
    parameter int BYTE_W     = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [SLOT_W-1:0] wslot,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SLOT_W-1:0] rslot,
    input  logic [BYTE_W-1:0] rbyte,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] slot_out [CELLS];

    for (genvar g = 0; g < CELLS; g++) begin : g_slot
        logic [DATA_W-1:0] mem [CELL_BYTES];

        // Write the addressed byte of this slot.
        always_ff @(posedge clk) begin
            if (we && (wslot == SLOT_W'(g))) mem[wbyte] <= wdata;
        end

        assign slot_out[g] = mem[rbyte];
    end

    assign rdata = slot_out[rslot];

endmodule

// File: rtl/utxb_rd_ctrl.sv
// Read-side control: walks the oldest complete cell byte by byte, high
// nibble then low nibble, advancing on each accepted read, and signals the
// release of a slot after the last nibble of a cell.
// Assumes `have_cell` is 1 only when the slot at the read pointer is complete.
module utxb_rd_ctrl
    import utxb_pkg::*;
#(
    parameter int CELLS      = 3,
    parameter int CELL_BYTES = 53,
    parameter int SLOT_W     = 2,
    parameter int BYTE_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              have_cell,
    input  logic              nib_rd,
    input  logic [DATA_W-1:0] rdata,
    output logic [SLOT_W-1:0] rslot,
    output logic [BYTE_W-1:0] rbyte,
    output logic              nib_vld,
    output logic [NIB_W-1:0]  nib,
    output logic              nib_soc,
    output logic              rel
);

    localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(CELL_BYTES - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(CELLS - 1);

    logic half;
    logic take;

    assign nib_vld = have_cell;
    assign nib     = half ? rdata[NIB_W-1:0] : rdata[DATA_W-1:NIB_W];
    assign nib_soc = have_cell && (rbyte == '0) && !half;
    assign take    = have_cell && nib_rd;
    assign rel     = take && half && (rbyte == LAST_BYTE);

    // Step through nibbles, bytes and slots on each consumed nibble.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half  <= 1'b0;
            rbyte <= '0;
            rslot <= '0;
        end else if (take) begin
            half <= !half;
            if (half) begin
                if (rbyte == LAST_BYTE) begin
                    rbyte <= '0;
                    rslot <= (rslot == LAST_SLOT) ? '0 : rslot + 1'b1;
                end else begin
                    rbyte <= rbyte + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/utxb_led.sv
// LED stretcher: holds the active-low LED output on for LED_CYC clock
// cycles after each trigger; a new trigger restarts the full count.
module utxb_led #(
    parameter int LED_CYC = 223
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic led_n
);

    localparam int CNT_W = $clog2(LED_CYC + 1);

    logic [CNT_W-1:0] cnt;

    // Reload on trigger, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (trig)       cnt <= CNT_W'(LED_CYC);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign led_n = (cnt == '0);

endmodule

// File: rtl/utx_cell_buffer.sv
// UTOPIA transmit cell buffer top level. Accepts bytes from the ATM-layer
// side, keeps up to CELLS complete cells, and offers them nibble by nibble
// to the framer. Assumes one clock domain for both sides.
module utx_cell_buffer
    import utxb_pkg::*;
#(
    parameter int CELLS      = 3,
    parameter int CELL_BYTES = 53,
    parameter int LED_CYC    = 223
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_par,
    input  logic              tx_soc,
    input  logic              tx_en_n,
    output logic              tx_cav,
    input  logic              nib_rd,
    output logic              nib_vld,
    output logic [NIB_W-1:0]  nib,
    output logic              nib_soc,
    output logic              par_err,
    output logic              ovf_flag,
    output logic              led_n
);

    localparam int SLOT_W = (CELLS > 1) ? $clog2(CELLS) : 1;
    localparam int BYTE_W = $clog2(CELL_BYTES);
    localparam int OCC_W  = $clog2(CELLS + 1);

    logic [OCC_W-1:0]  occ;
    logic              room;
    logic              we, commit, soc_ok, rel;
    logic [SLOT_W-1:0] wslot, rslot;
    logic [BYTE_W-1:0] wbyte, rbyte;
    logic [DATA_W-1:0] rdata;

    assign room   = (occ < OCC_W'(CELLS));
    assign tx_cav = room;

    // Count complete cells held: up on commit, down on release.
    always_ff @(posedge clk) begin
        if (!rst_n)               occ <= '0;
        else if (commit && !rel)  occ <= occ + 1'b1;
        else if (!commit && rel)  occ <= occ - 1'b1;
    end

    utxb_wr_ctrl #(
        .CELLS(CELLS), .CELL_BYTES(CELL_BYTES), .SLOT_W(SLOT_W), .BYTE_W(BYTE_W)
    ) u_wr (
        .clk(clk), .rst_n(rst_n), .data(tx_data), .par(tx_par), .soc(tx_soc),
        .en_n(tx_en_n), .room(room), .we(we), .wslot(wslot), .wbyte(wbyte),
        .commit(commit), .soc_ok(soc_ok), .par_err(par_err), .ovf(ovf_flag)
    );

    utxb_store #(
        .CELLS(CELLS), .CELL_BYTES(CELL_BYTES), .SLOT_W(SLOT_W), .BYTE_W(BYTE_W)
    ) u_store (
        .clk(clk), .we(we), .wslot(wslot), .wbyte(wbyte), .wdata(tx_data),
        .rslot(rslot), .rbyte(rbyte), .rdata(rdata)
    );

    utxb_rd_ctrl #(
        .CELLS(CELLS), .CELL_BYTES(CELL_BYTES), .SLOT_W(SLOT_W), .BYTE_W(BYTE_W)
    ) u_rd (
        .clk(clk), .rst_n(rst_n), .have_cell(occ != '0), .nib_rd(nib_rd),
        .rdata(rdata), .rslot(rslot), .rbyte(rbyte), .nib_vld(nib_vld),
        .nib(nib), .nib_soc(nib_soc), .rel(rel)
    );

    utxb_led #(.LED_CYC(LED_CYC)) u_led (
        .clk(clk), .rst_n(rst_n), .trig(soc_ok), .led_n(led_n)
    );

endmodule

// File: rtl/utx_cell_buffer_chk.sv
// Protocol checker for utx_cell_buffer, attached through bind.
// Observes ports plus the held-cell count.
module utx_cell_buffer_chk #(
    parameter int CELLS = 3,
    parameter int OCC_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_en_n,
    input logic             tx_soc,
    input logic             tx_cav,
    input logic             nib_rd,
    input logic             nib_vld,
    input logic [3:0]       nib,
    input logic             nib_soc,
    input logic             par_err,
    input logic             ovf_flag,
    input logic             led_n,
    input logic [OCC_W-1:0] occ
);

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_W'(CELLS));                                              // R2

    AST_FULL_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en_n && !tx_cav) |=> ovf_flag);                                // R10

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);                                             // R10

    AST_NIB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (nib_vld && !nib_rd) |=> (nib_vld && $stable(nib) && $stable(nib_soc))); // R5

    AST_NEW_CELL_SOC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nib_vld) |-> nib_soc);                                        // R3

    AST_LED_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en_n && tx_soc && tx_cav) |=> !led_n);                         // R7

    AST_PAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> $past(!tx_en_n));                                       // R4

endmodule

bind utx_cell_buffer utx_cell_buffer_chk #(.CELLS(CELLS), .OCC_W(OCC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_en_n(tx_en_n), .tx_soc(tx_soc),
    .tx_cav(tx_cav), .nib_rd(nib_rd), .nib_vld(nib_vld), .nib(nib),
    .nib_soc(nib_soc), .par_err(par_err), .ovf_flag(ovf_flag),
    .led_n(led_n), .occ(occ)
);

// File: tb/sim_utx_cell_buffer.sv
// Self-checking bench for utx_cell_buffer; inputs driven on the falling
// edge, outputs sampled on the falling edge.
module sim_utx_cell_buffer;

    localparam int CLK_PERIOD = 10;
    localparam int CELLS      = 3;
    localparam int CB         = 53;
    localparam int LED_CYC    = 223;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_par = 1'b0;
    logic       tx_soc = 1'b0;
    logic       tx_en_n = 1'b1;
    logic       nib_rd = 1'b0;
    logic       tx_cav, nib_vld, nib_soc, par_err, ovf_flag, led_n;
    logic [3:0] nib;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    utx_cell_buffer #(.CELLS(CELLS), .CELL_BYTES(CB), .LED_CYC(LED_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_par(tx_par),
        .tx_soc(tx_soc), .tx_en_n(tx_en_n), .tx_cav(tx_cav), .nib_rd(nib_rd),
        .nib_vld(nib_vld), .nib(nib), .nib_soc(nib_soc), .par_err(par_err),
        .ovf_flag(ovf_flag), .led_n(led_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 37 + i * 11 + 5) & 255);
    endfunction

    // One byte over one clock edge; returns at the next falling edge.
    task automatic send_byte(input logic [7:0] d, input bit soc, input bit bad);
        tx_data = d;
        tx_soc  = soc;
        tx_par  = bad ? (^d) : ~(^d);
        tx_en_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        tx_en_n = 1'b1;
        tx_soc  = 1'b0;
    endtask

    task automatic send_cell(input int seed, input bit push, input bit chk_r3);
        for (int i = 0; i < CB; i++) begin
            send_byte(pat(seed, i), i == 0, 1'b0);
            if (push) exp_q.push_back(pat(seed, i));
            if (chk_r3) check("R3 valid only after last byte", nib_vld, i == CB - 1);
        end
    endtask

    // Pull one cell and compare nibbles, order and start marker (R5, R6).
    task automatic pull_cell();
        for (int b = 0; b < CB; b++) begin
            logic [7:0] d;
            d = exp_q.pop_front();
            for (int h = 0; h < 2; h++) begin
                check("R5 valid during cell", nib_vld, 1);
                check("R6 nibble order", nib, h ? d[3:0] : d[7:4]);
                check("R5 start marker", nib_soc, (b == 0 && h == 0));
                nib_rd = 1'b1;
                @(posedge clk);
                @(negedge clk);
                nib_rd = 1'b0;
            end
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R8 cav after reset", tx_cav, 1);
        check("R8 vld after reset", nib_vld, 0);
        check("R8 par after reset", par_err, 0);
        check("R8 ovf after reset", ovf_flag, 0);
        check("R8 led after reset", led_n, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual running expected done");
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int lowcnt;
        @(negedge clk);
        do_reset();

        // R1: start bytes with enable high are not taken.
        tx_data = 8'hA5; tx_soc = 1'b1; tx_en_n = 1'b1;
        repeat (3) @(negedge clk);
        tx_soc = 1'b0;
        check("R1 no LED without enable", led_n, 1);
        // R11: stray bytes without a start are ignored.
        for (int i = 0; i < 10; i++) send_byte(8'(i + 100), 1'b0, 1'b1);
        check("R11 no parity flag on stray", par_err, 0);
        check("R11 nothing stored", nib_vld, 0);
        check("R11 no overflow", ovf_flag, 0);

        // R3: a cell appears only once complete; data proves no strays kept.
        send_cell(1, 1'b1, 1'b1);
        pull_cell();
        check("R11 buffer empty after one cell", nib_vld, 0);

        // R7: LED stretch length after a lone start byte.
        send_byte(8'h33, 1'b1, 1'b0);
        lowcnt = 0;
        while (!led_n && lowcnt < 1000) begin
            lowcnt++;
            @(negedge clk);
        end
        check("R7 LED low cycles", lowcnt, LED_CYC);

        // R9: partial cell cut by a new start is discarded.
        for (int i = 0; i < 20; i++) send_byte(8'(200 + i), 1'b0, 1'b0);
        check("R9 partial not offered", nib_vld, 0);
        send_cell(2, 1'b1, 1'b0);
        pull_cell();
        check("R9 only restarted cell held", nib_vld, 0);

        // R2 / R10: fill all slots, then overflow.
        send_cell(3, 1'b1, 1'b0);
        check("R2 cav with one held", tx_cav, 1);
        send_cell(4, 1'b1, 1'b0);
        check("R2 cav with two held", tx_cav, 1);
        send_cell(5, 1'b1, 1'b0);
        check("R2 cav with three held", tx_cav, 0);
        send_cell(6, 1'b0, 1'b0);
        check("R10 overflow flag", ovf_flag, 1);
        check("R2 cav still low", tx_cav, 0);
        repeat (4) @(negedge clk);   // R5: output must hold while not read
        pull_cell();
        check("R2 cav back after drain", tx_cav, 1);
        check("R10 overflow sticky", ovf_flag, 1);
        pull_cell();
        pull_cell();
        check("R10 dropped cell absent", nib_vld, 0);

        // R4: every byte value, bad parity on every third byte.
        for (int v = 0; v < 5 * CB; v++) begin
            bit bad;
            bad = (v % 3 == 1);
            send_byte(8'(v & 255), (v % CB) == 0, bad);
            exp_q.push_back(8'(v & 255));
            check("R4 parity pulse", par_err, bad);
            if ((v % CB) == CB - 1) pull_cell();
        end
        @(negedge clk);
        check("R4 pulse ends", par_err, 0);

        // R8: reset in the middle of traffic.
        send_cell(7, 1'b0, 1'b0);
        send_cell(8, 1'b0, 1'b0);
        for (int i = 0; i < 9; i++) send_byte(pat(9, i), i == 0, 1'b0);
        exp_q.delete();
        do_reset();
        send_cell(10, 1'b1, 1'b1);
        pull_cell();

        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule